// File: doc/BRIEF.md
# Lane Buffer Start Character Detector

This block watches the decoded character stream of a single JESD204B-style receive lane and decides the moment at which writing into that lane's elastic buffer should begin. Each valid character carries a byte and a flag that marks it as a control (K) character. The trigger condition is programmable in two ways. In specific-match mode, only a chosen byte with a chosen control or data qualifier starts buffering. In open mode, the first data character starts it.

Once triggered, the block raises a one-clock start pulse and holds a buffering level until the lane is resynchronised or reset. Two further functions sit beside the trigger. The first checks configuration bytes received during the alignment sequence against expected bytes and keeps a sticky error flag, which can be masked for transmitters that do not send that sequence. The second produces the signal that ends comma alignment, built either from the alignment-done condition together with a programmed bit, or from the programmed bit alone.

Configuration inputs are intended to come from a register whose power-up values are: match byte 0x1C (the K28.0 character), specific-match on, control qualifier on, lane-sync masking off and comma combining on. All outputs are registered, so every result appears one clock after the inputs that cause it.

Top module: `lane_bufstart_det`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next outputs are `buf_start_o`=0, `buffering_o`=0, `ila_cfg_err_o`=0 and `comma_off_o`=0, whatever the other inputs do.
- R2: With `cfg_match_specific_i`=1 and `cfg_match_ctrl_i`=1, a valid character starts buffering only if its byte equals `cfg_match_byte_i` and `ch_is_ctrl_i`=1. The match byte is fully programmable.
- R3: With `cfg_match_specific_i`=1 and `cfg_match_ctrl_i`=0, a valid character starts buffering only if its byte equals `cfg_match_byte_i` and `ch_is_ctrl_i`=0.
- R4: With `cfg_match_specific_i`=0, the first valid character with `ch_is_ctrl_i`=0 starts buffering whatever its byte. Control characters never start it in this mode.
- R5: A character presented with `ch_valid_i`=0 never starts buffering.
- R6: A qualifying character sampled at edge N gives `buf_start_o`=1 and `buffering_o`=1 after edge N. `buf_start_o` returns to 0 after edge N+1.
- R7: While buffering, further qualifying characters give no new start pulse, and `buffering_o` stays high.
- R8: `resync_i` high at an edge clears `buffering_o` after that edge. A qualifying character in the same cycle as `resync_i` is ignored. A later qualifying character starts buffering again.
- R9: A valid character received while `ila_cfg_phase_i`=1, whose byte differs from `ila_exp_byte_i`, sets `ila_cfg_err_o` after that edge while `cfg_no_lane_sync_i`=0. The flag stays set until reset. Equal bytes never set it.
- R10: With `cfg_no_lane_sync_i`=1, configuration mismatches never set `ila_cfg_err_o`.
- R11: After each edge, `comma_off_o` equals (`align_done_i` OR `align_prog_i`) when `cfg_comma_ena_i`=1, and equals `align_prog_i` alone when `cfg_comma_ena_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| resync_i | input | 1 | Lane resynchronisation; drops the buffering level |
| ch_valid_i | input | 1 | Character strobe |
| ch_byte_i | input | CHAR_W | Decoded character byte |
| ch_is_ctrl_i | input | 1 | 1 = control (K) character, 0 = data character |
| cfg_match_byte_i | input | CHAR_W | Programmed start byte |
| cfg_match_specific_i | input | 1 | 1 = start on the programmed byte, 0 = start on first data character |
| cfg_match_ctrl_i | input | 1 | 1 = programmed byte must be control, 0 = must be data |
| cfg_no_lane_sync_i | input | 1 | 1 = mask alignment-sequence configuration errors |
| cfg_comma_ena_i | input | 1 | 1 = combine alignment-done with programmed bit |
| align_done_i | input | 1 | Internal comma alignment done condition |
| align_prog_i | input | 1 | Programmed comma-align stop bit |
| ila_cfg_phase_i | input | 1 | High while configuration bytes of the alignment sequence arrive |
| ila_exp_byte_i | input | CHAR_W | Expected configuration byte |
| buf_start_o | output | 1 | One-clock buffer start pulse |
| buffering_o | output | 1 | High while the buffer is being written |
| comma_off_o | output | 1 | Turns comma alignment off |
| ila_cfg_err_o | output | 1 | Sticky configuration mismatch flag |

## Verification
The start trigger and the resynchronisation clear can land in the same clock. The bench holds buffering, then raises `resync_i` together with a character that would otherwise qualify. It checks that after that edge both `buf_start_o` and `buffering_o` are low. It then checks that one more qualifying character on its own restarts buffering with a single pulse. Reset against a mismatching configuration byte in the same cycle is also provoked, and the error flag must come out clear.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  localparam int unsigned LBS_CHAR_W = 8;

  typedef enum logic [1:0] {
    START_ANY_DATA   = 2'd0,
    START_MATCH_DATA = 2'd1,
    START_MATCH_CTRL = 2'd2
  } lbs_start_mode_e;

  function automatic lbs_start_mode_e lbs_pick_mode(input logic specific,
                                                    input logic want_ctrl);
    if (!specific)      return START_ANY_DATA;
    else if (want_ctrl) return START_MATCH_CTRL;
    else                return START_MATCH_DATA;
  endfunction

endpackage

// File: rtl/lbs_char_qual.sv
module lbs_char_qual
  import lbs_pkg::*;
#(
  parameter int unsigned CHAR_W = LBS_CHAR_W
) (
  input  logic              ch_valid_i,
  input  logic [CHAR_W-1:0] ch_byte_i,
  input  logic              ch_is_ctrl_i,
  input  logic [CHAR_W-1:0] match_byte_i,
  input  lbs_start_mode_e   mode_i,
  output logic              qualify_o
);

  function automatic logic char_hits(input lbs_start_mode_e md,
                                     input logic [CHAR_W-1:0] chr,
                                     input logic is_k,
                                     input logic [CHAR_W-1:0] want);
    case (md)
      START_MATCH_CTRL: return (chr == want) && is_k;
      START_MATCH_DATA: return (chr == want) && !is_k;
      START_ANY_DATA:   return !is_k;
      default:          return 1'b0;
    endcase
  endfunction

  assign qualify_o = ch_valid_i && char_hits(mode_i, ch_byte_i, ch_is_ctrl_i, match_byte_i);

endmodule

// File: rtl/lbs_start_ctl.sv
module lbs_start_ctl (
  input  logic clk_i,
  input  logic rst_i,
  input  logic resync_i,
  input  logic qualify_i,
  output logic buf_start_o,
  output logic buffering_o
);

  logic start_q;
  logic buf_q;
  logic fire;

  assign fire = qualify_i && !buf_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || resync_i) begin
      start_q <= 1'b0;
      buf_q   <= 1'b0;
    end else begin
      start_q <= fire;
      if (fire) buf_q <= 1'b1;
    end
  end

  assign buf_start_o = start_q;
  assign buffering_o = buf_q;

  // R6
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    buf_start_o |=> !buf_start_o);

  // R6
  start_sets_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    buf_start_o |-> buffering_o);

  // R6
  first_hit_fires_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (qualify_i && !buffering_o && !resync_i) |=> buf_start_o);

  // R7
  level_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (buffering_o && !resync_i) |=> buffering_o);

  // R7
  no_repeat_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    buffering_o |=> !buf_start_o);

  // R8
  resync_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    resync_i |=> (!buffering_o && !buf_start_o));

endmodule

// File: rtl/lbs_ila_chk.sv
module lbs_ila_chk
  import lbs_pkg::*;
#(
  parameter int unsigned CHAR_W = LBS_CHAR_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ch_valid_i,
  input  logic [CHAR_W-1:0] ch_byte_i,
  input  logic              cfg_phase_i,
  input  logic [CHAR_W-1:0] exp_byte_i,
  input  logic              no_lane_sync_i,
  output logic              err_o
);

  logic mismatch;
  logic err_q;

  assign mismatch = cfg_phase_i && ch_valid_i && (ch_byte_i != exp_byte_i) && !no_lane_sync_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)         err_q <= 1'b0;
    else if (mismatch) err_q <= 1'b1;
  end

  assign err_o = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> err_o);

  // R10
  err_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (no_lane_sync_i && !err_o) |=> !err_o);

  // R9
  err_needs_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cfg_phase_i && !err_o) |=> !err_o);

endmodule

// File: rtl/lbs_comma_ctl.sv
module lbs_comma_ctl #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic comma_ena_i,
  input  logic align_done_i,
  input  logic align_prog_i,
  output logic comma_off_o
);

  logic off_next;

  assign off_next = comma_ena_i ? (align_done_i || align_prog_i) : align_prog_i;

  generate
    if (REG_OUT) begin : g_reg
      logic off_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) off_q <= 1'b0;
        else       off_q <= off_next;
      end
      assign comma_off_o = off_q;

      // R11
      prog_alone_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !comma_ena_i |=> (comma_off_o == $past(align_prog_i)));

      // R11
      done_combined_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (comma_ena_i && align_done_i) |=> comma_off_o);
    end else begin : g_comb
      assign comma_off_o = rst_i ? 1'b0 : off_next;

      // R11
      prog_alone_chk: assert property (@(posedge clk_i)
        (!rst_i && !comma_ena_i) |-> (comma_off_o == align_prog_i));
    end
  endgenerate

endmodule

// File: rtl/lane_bufstart_det.sv
module lane_bufstart_det
  import lbs_pkg::*;
#(
  parameter int unsigned CHAR_W    = LBS_CHAR_W,
  parameter bit          COMMA_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              resync_i,
  input  logic              ch_valid_i,
  input  logic [CHAR_W-1:0] ch_byte_i,
  input  logic              ch_is_ctrl_i,
  input  logic [CHAR_W-1:0] cfg_match_byte_i,
  input  logic              cfg_match_specific_i,
  input  logic              cfg_match_ctrl_i,
  input  logic              cfg_no_lane_sync_i,
  input  logic              cfg_comma_ena_i,
  input  logic              align_done_i,
  input  logic              align_prog_i,
  input  logic              ila_cfg_phase_i,
  input  logic [CHAR_W-1:0] ila_exp_byte_i,
  output logic              buf_start_o,
  output logic              buffering_o,
  output logic              comma_off_o,
  output logic              ila_cfg_err_o
);

  lbs_start_mode_e start_mode;
  logic            char_qualifies;

  assign start_mode = lbs_pick_mode(cfg_match_specific_i, cfg_match_ctrl_i);

  lbs_char_qual #(.CHAR_W(CHAR_W)) u_qual (
    .ch_valid_i   (ch_valid_i),
    .ch_byte_i    (ch_byte_i),
    .ch_is_ctrl_i (ch_is_ctrl_i),
    .match_byte_i (cfg_match_byte_i),
    .mode_i       (start_mode),
    .qualify_o    (char_qualifies)
  );

  lbs_start_ctl u_start (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .resync_i    (resync_i),
    .qualify_i   (char_qualifies),
    .buf_start_o (buf_start_o),
    .buffering_o (buffering_o)
  );

  lbs_ila_chk #(.CHAR_W(CHAR_W)) u_ila (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .ch_valid_i     (ch_valid_i),
    .ch_byte_i      (ch_byte_i),
    .cfg_phase_i    (ila_cfg_phase_i),
    .exp_byte_i     (ila_exp_byte_i),
    .no_lane_sync_i (cfg_no_lane_sync_i),
    .err_o          (ila_cfg_err_o)
  );

  lbs_comma_ctl #(.REG_OUT(COMMA_REG)) u_comma (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .comma_ena_i  (cfg_comma_ena_i),
    .align_done_i (align_done_i),
    .align_prog_i (align_prog_i),
    .comma_off_o  (comma_off_o)
  );

  // R5
  invalid_no_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ch_valid_i && !buffering_o) |=> !buf_start_o);

  // R4
  ctrl_open_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cfg_match_specific_i && ch_is_ctrl_i && !buffering_o) |=> !buf_start_o);

endmodule

// File: tb/lane_bufstart_det_bench.sv
`timescale 1ns/1ps
module lane_bufstart_det_bench;

  logic       clk = 1'b0;
  logic       rst, resync, ch_valid, ch_is_ctrl;
  logic [7:0] ch_byte, m_byte, exp_byte;
  logic       m_spec, m_ctrl, nls, c_ena, a_done, a_prog, cfg_phase;
  logic       buf_start, buffering, comma_off, cfg_err;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  lane_bufstart_det u_lane_bufstart_det (
    .clk_i(clk), .rst_i(rst), .resync_i(resync),
    .ch_valid_i(ch_valid), .ch_byte_i(ch_byte), .ch_is_ctrl_i(ch_is_ctrl),
    .cfg_match_byte_i(m_byte), .cfg_match_specific_i(m_spec), .cfg_match_ctrl_i(m_ctrl),
    .cfg_no_lane_sync_i(nls), .cfg_comma_ena_i(c_ena),
    .align_done_i(a_done), .align_prog_i(a_prog),
    .ila_cfg_phase_i(cfg_phase), .ila_exp_byte_i(exp_byte),
    .buf_start_o(buf_start), .buffering_o(buffering),
    .comma_off_o(comma_off), .ila_cfg_err_o(cfg_err)
  );

  typedef struct packed {
    logic       spec;
    logic       mctrl;
    logic [7:0] mbyte;
    logic [7:0] chr;
    logic       k;
    logic       vld;
    logic       hit;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'h1C, 8'h1C, 1'b1, 1'b1, 1'b1},  // R2 K28.0 control match
    '{1'b1, 1'b1, 8'h1C, 8'h1C, 1'b0, 1'b1, 1'b0},  // R2 same byte as data
    '{1'b1, 1'b1, 8'h1C, 8'hBC, 1'b1, 1'b1, 1'b0},  // R2 other control byte
    '{1'b1, 1'b0, 8'h5A, 8'h5A, 1'b0, 1'b1, 1'b1},  // R3 data match
    '{1'b1, 1'b0, 8'h5A, 8'h5A, 1'b1, 1'b1, 1'b0},  // R3 byte as control
    '{1'b1, 1'b0, 8'h5A, 8'h5B, 1'b0, 1'b1, 1'b0},  // R3 wrong byte
    '{1'b0, 1'b1, 8'h1C, 8'h37, 1'b0, 1'b1, 1'b1},  // R4 any data
    '{1'b0, 1'b0, 8'h00, 8'h1C, 1'b1, 1'b1, 1'b0},  // R4 control refused
    '{1'b1, 1'b1, 8'h1C, 8'h1C, 1'b1, 1'b0, 1'b0},  // R5 not valid
    '{1'b0, 1'b0, 8'h00, 8'h42, 1'b0, 1'b0, 1'b0},  // R5 not valid, open mode
    '{1'b1, 1'b1, 8'hF7, 8'hF7, 1'b1, 1'b1, 1'b1}   // R2 programmed byte
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle_char();
    ch_valid = 1'b0; ch_byte = 8'h00; ch_is_ctrl = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; resync = 1'b0; idle_char(); cfg_phase = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic k);
    ch_valid = 1'b1; ch_byte = b; ch_is_ctrl = k;
    tick();
    idle_char();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; resync = 1'b0; idle_char();
    m_byte = 8'h1C; m_spec = 1'b1; m_ctrl = 1'b1; nls = 1'b0; c_ena = 1'b1;
    a_done = 1'b0; a_prog = 1'b0; cfg_phase = 1'b0; exp_byte = 8'h00;
    tick(); tick();
    rst = 1'b0;
    tick();

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      do_reset();
      m_spec = VECS[i].spec; m_ctrl = VECS[i].mctrl; m_byte = VECS[i].mbyte;
      ch_valid = VECS[i].vld; ch_byte = VECS[i].chr; ch_is_ctrl = VECS[i].k;
      tick();
      idle_char();
      chk($sformatf("R2/R3/R4/R5 vec %0d start", i), buf_start, VECS[i].hit);
      chk($sformatf("R6 vec %0d level", i), buffering, VECS[i].hit);
      tick();
      chk($sformatf("R6 vec %0d pulse end", i), buf_start, 1'b0);
    end

    // R7: later matches ignored while buffering
    m_spec = 1'b1; m_ctrl = 1'b1; m_byte = 8'h1C;
    do_reset();
    send(8'h1C, 1'b1);
    chk("R7 first start", buf_start, 1'b1);
    send(8'h1C, 1'b1);
    chk("R7 no second pulse", buf_start, 1'b0);
    chk("R7 level held", buffering, 1'b1);
    tick();
    chk("R7 level held idle", buffering, 1'b1);

    // R8: resync clears; resync + match same cycle ignored; restart later
    resync = 1'b1; tick(); resync = 1'b0;
    chk("R8 resync clears", buffering, 1'b0);
    resync = 1'b1; ch_valid = 1'b1; ch_byte = 8'h1C; ch_is_ctrl = 1'b1;
    tick();
    resync = 1'b0; idle_char();
    chk("R8 collide no pulse", buf_start, 1'b0);
    chk("R8 collide no level", buffering, 1'b0);
    send(8'h1C, 1'b1);
    chk("R8 restart pulse", buf_start, 1'b1);
    chk("R8 restart level", buffering, 1'b1);

    // R9: config mismatch sets sticky error
    do_reset();
    nls = 1'b0; cfg_phase = 1'b1; exp_byte = 8'h33;
    send(8'h33, 1'b0);
    chk("R9 equal byte no error", cfg_err, 1'b0);
    send(8'h34, 1'b0);
    chk("R9 mismatch sets", cfg_err, 1'b1);
    cfg_phase = 1'b0; tick(); tick();
    chk("R9 sticky", cfg_err, 1'b1);

    // R1: reset clears everything, even with mismatch and match in same cycle
    a_prog = 1'b1; c_ena = 1'b1; tick();
    chk("R11 prog drives off", comma_off, 1'b1);
    rst = 1'b1; cfg_phase = 1'b1; ch_valid = 1'b1; ch_byte = 8'h1C; ch_is_ctrl = 1'b1;
    tick();
    chk("R1 err clear", cfg_err, 1'b0);
    chk("R1 start clear", buf_start, 1'b0);
    chk("R1 level clear", buffering, 1'b0);
    chk("R1 comma clear", comma_off, 1'b0);
    rst = 1'b0; idle_char(); cfg_phase = 1'b0; a_prog = 1'b0;
    tick();

    // R10: no-lane-sync masks mismatches
    do_reset();
    nls = 1'b1; cfg_phase = 1'b1; exp_byte = 8'h10;
    send(8'h99, 1'b0);
    send(8'h98, 1'b0);
    chk("R10 masked", cfg_err, 1'b0);
    nls = 1'b0; cfg_phase = 1'b0;

    // R11: comma alignment off control
    c_ena = 1'b1; a_done = 1'b1; a_prog = 1'b0; tick();
    chk("R11 ena done", comma_off, 1'b1);
    c_ena = 1'b0; tick();
    chk("R11 no ena done ignored", comma_off, 1'b0);
    a_prog = 1'b1; tick();
    chk("R11 no ena prog", comma_off, 1'b1);
    c_ena = 1'b1; a_done = 1'b0; a_prog = 1'b0; tick();
    chk("R11 ena both low", comma_off, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule